// File: doc/BRIEF.md
# Debug Run-Control Unit

This unit is the run-control slice of a debug module serving a small multi-hart system. A debugger reaches it over an APB register port that is addressed in bytes. Through a control register it picks a hart, optionally widens the pick to a group through a per-hart mask, and issues halt and resume requests. Those requests reach the harts as registered per-hart lines. A status register combines the halted, running, resume-acknowledge and existence state of the chosen harts into any/all flags.

The unit also accepts an abstract register-access command. It checks the command's fields, rejects a command that arrives while one is in flight, and presents an accepted command on a simple valid/done port until the executing side finishes it. Each hart's resume handshake runs as a small state machine. RS_IDLE moves to RS_WAIT when a resume is issued to that hart, and RS_WAIT moves back to RS_IDLE once the hart reports running. The command path has two states. CS_IDLE moves to CS_BUSY when a command is accepted, and CS_BUSY moves back to CS_IDLE when done is seen.

Top module: `dbg_run_ctrl`

## Requirements
- R1: Registers sit at byte offsets 0x00 control, 0x04 status, 0x08 group mask, 0x0C command and 0x10 command status. An access whose address has nonzero low two bits, or matches no register, writes nothing and reads zero.
- R2: The control register holds the hart index in bits [11:8] and the group enable in bit 3, and reads back only those two fields. With the group enable clear, only the indexed hart is selected. With it set, the indexed hart and every hart whose bit is set in the mask register (bits [N-1:0], readable) are selected. A control write acts on the selection it writes.
- R3: A control write sets halt_req of every selected hart to the written bit 1 and leaves unselected harts unchanged. The change appears in the cycle after the APB access phase, and halt_req changes at no other time.
- R4: A control write with bit 2 set and bit 1 clear raises resume_req on each selected hart from the next cycle. The request stays high until that hart's running input is seen, then drops. A write with both bit 1 and bit 2 set starts no resume.
- R5: A hart's resume acknowledge clears when a resume is started on it and sets in the same cycle its resume_req drops.
- R6: Status bits: 0 any halted, 1 all halted, 2 any running, 3 all running, 4 any nonexistent, 5 all nonexistent, 6 any resume-ack, 7 all resume-ack. An "all" flag is clear whenever the selected set includes a nonexistent hart or no hart.
- R7: A hart index of N or more names a nonexistent hart. It drives no request line, it sets any-nonexistent, and it sets all-nonexistent only when no mask bit is also selected.
- R8: A command write (regno [15:0], write bit 16, transfer bit 17, size [22:20]) taken while idle with no error raises cmd_valid in the next cycle. The fields are held stable until cmd_done, and cmd_valid drops in the cycle after cmd_done.
- R9: With the transfer bit clear, regno and size are ignored: the command is launched with cmd_regno and cmd_size presented as zero, and no size check is made.
- R10: With the transfer bit set and size above 2, the command is not launched and the error field becomes 2.
- R11: A command write while busy sets the error field to 1 if it was zero and leaves the command in flight unchanged. A command write while the error field is nonzero is ignored. Command status reads busy in bit 0 and the error in bits [3:1], and writing ones to bits [3:1] clears those error bits.
- R12: After reset all request lines, cmd_valid, the control fields, the mask and the error are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| hart_halted | input | N | Per-hart halted state |
| hart_running | input | N | Per-hart running state |
| halt_req | output | N | Per-hart registered halt request |
| resume_req | output | N | Per-hart registered resume request |
| cmd_valid | output | 1 | Command in flight |
| cmd_write | output | 1 | Command direction |
| cmd_xfer | output | 1 | Command transfer bit |
| cmd_size | output | 3 | Command access size, gated |
| cmd_regno | output | 16 | Command register number, gated |
| cmd_done | input | 1 | Command completion |

## Verification
The hardest states to reach are the mixed selections. One case is a nonexistent hart index together with a nonempty group. Another is a resume issued while some selected harts are still held in RS_WAIT because their running input stays low. The stimulus reaches these by building the mask first and then rewriting the control register with an out-of-range index and the group bit. It holds individual running inputs low across several cycles before releasing them. A behavioural model in the bench tracks every request line and the command port each cycle. It also predicts each status read over the same selected set.

// File: rtl/dbgrc_pkg.sv
package dbgrc_pkg;
    typedef enum logic { RS_IDLE, RS_WAIT } rs_state_e;
    typedef enum logic { CS_IDLE, CS_BUSY } cs_state_e;

    localparam logic [2:0] ERR_NONE   = 3'd0;
    localparam logic [2:0] ERR_BUSY   = 3'd1;
    localparam logic [2:0] ERR_NOTSUP = 3'd2;

    localparam int OFS_CTRL    = 'h00;
    localparam int OFS_STAT    = 'h04;
    localparam int OFS_MASK    = 'h08;
    localparam int OFS_CMD     = 'h0C;
    localparam int OFS_CMDSTAT = 'h10;

    localparam int MAX_SIZE = 2;
endpackage

// File: rtl/dbgrc_select.sv
module dbgrc_select #(
    parameter int N      = 4,
    parameter int HSEL_W = 4
) (
    input  logic [HSEL_W-1:0] hs,
    input  logic              group_en,
    input  logic [N-1:0]      mask,
    output logic [N-1:0]      sel,
    output logic              hs_absent
);
    for (genvar i = 0; i < N; i++) begin : g_sel
        assign sel[i] = (hs == HSEL_W'(i)) | (group_en & mask[i]);
    end
    assign hs_absent = (32'(hs) >= N);
endmodule

// File: rtl/dbgrc_hart.sv
module dbgrc_hart
    import dbgrc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sel,
    input  logic ctrl_wr,
    input  logic halt_val,
    input  logic resume_go,
    input  logic running,
    output logic halt_req,
    output logic resume_req,
    output logic ack
);
    rs_state_e state_q, state_d;
    logic      halt_q, ack_q, ack_d;

    always_comb begin
        state_d = state_q;
        ack_d   = ack_q;
        unique case (state_q)
            RS_IDLE: if (resume_go && sel) begin
                state_d = RS_WAIT;
                ack_d   = 1'b0;
            end
            RS_WAIT: if (resume_go && sel) begin
                ack_d   = 1'b0;
            end else if (running) begin
                state_d = RS_IDLE;
                ack_d   = 1'b1;
            end
            default: state_d = RS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RS_IDLE;
            ack_q   <= 1'b0;
            halt_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            ack_q   <= ack_d;
            if (ctrl_wr && sel) halt_q <= halt_val;
        end
    end

    always_comb begin
        halt_req   = halt_q;
        resume_req = (state_q == RS_WAIT);
        ack        = ack_q;
    end
endmodule

// File: rtl/dbgrc_status.sv
module dbgrc_status #(
    parameter int N = 4
) (
    input  logic [N-1:0] sel,
    input  logic         hs_absent,
    input  logic         group_en,
    input  logic [N-1:0] mask,
    input  logic [N-1:0] halted,
    input  logic [N-1:0] running,
    input  logic [N-1:0] ack,
    output logic [7:0]   flags
);
    logic all_ok;
    always_comb begin
        all_ok   = (|sel) && !hs_absent;
        flags    = '0;
        flags[0] = |(sel & halted);
        flags[1] = all_ok && ((sel & ~halted) == '0);
        flags[2] = |(sel & running);
        flags[3] = all_ok && ((sel & ~running) == '0);
        flags[4] = hs_absent;
        flags[5] = hs_absent && !(group_en && (|mask));
        flags[6] = |(sel & ack);
        flags[7] = all_ok && ((sel & ~ack) == '0);
    end
endmodule

// File: rtl/dbgrc_cmd.sv
module dbgrc_cmd
    import dbgrc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_wr,
    input  logic        stat_wr,
    input  logic [31:0] wdata,
    input  logic        done,
    output logic        valid,
    output logic        busy,
    output logic [2:0]  err,
    output logic        f_write,
    output logic        f_xfer,
    output logic [2:0]  f_size,
    output logic [15:0] f_regno
);
    cs_state_e   state_q, state_d;
    logic [2:0]  err_q, err_d;
    logic        load;
    logic        wx;
    logic [2:0]  wsize;
    logic        wr_q, xfer_q;
    logic [2:0]  size_q;
    logic [15:0] regno_q;

    assign wx    = wdata[17];
    assign wsize = wdata[22:20];

    always_comb begin
        state_d = state_q;
        err_d   = err_q;
        load    = 1'b0;
        unique case (state_q)
            CS_IDLE: if (cmd_wr && err_q == ERR_NONE) begin
                if (wx && 32'(wsize) > MAX_SIZE) begin
                    err_d = ERR_NOTSUP;
                end else begin
                    load    = 1'b1;
                    state_d = CS_BUSY;
                end
            end
            CS_BUSY: begin
                if (cmd_wr && err_q == ERR_NONE) err_d = ERR_BUSY;
                if (done) state_d = CS_IDLE;
            end
            default: state_d = CS_IDLE;
        endcase
        if (stat_wr) err_d = err_d & ~wdata[3:1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CS_IDLE;
            err_q   <= ERR_NONE;
            wr_q    <= 1'b0;
            xfer_q  <= 1'b0;
            size_q  <= '0;
            regno_q <= '0;
        end else begin
            state_q <= state_d;
            err_q   <= err_d;
            if (load) begin
                wr_q    <= wdata[16];
                xfer_q  <= wx;
                size_q  <= wx ? wsize : 3'd0;
                regno_q <= wx ? wdata[15:0] : 16'd0;
            end
        end
    end

    always_comb begin
        valid   = (state_q == CS_BUSY);
        busy    = valid;
        err     = err_q;
        f_write = wr_q;
        f_xfer  = xfer_q;
        f_size  = size_q;
        f_regno = regno_q;
    end
endmodule

// File: rtl/dbg_run_ctrl.sv
module dbg_run_ctrl
    import dbgrc_pkg::*;
#(
    parameter int N      = 4,
    parameter int HSEL_W = 4,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [31:0]       pwdata,
    output logic [31:0]       prdata,
    input  logic [N-1:0]      hart_halted,
    input  logic [N-1:0]      hart_running,
    output logic [N-1:0]      halt_req,
    output logic [N-1:0]      resume_req,
    output logic              cmd_valid,
    output logic              cmd_write,
    output logic              cmd_xfer,
    output logic [2:0]        cmd_size,
    output logic [15:0]       cmd_regno,
    input  logic              cmd_done
);
    localparam int HS_LSB = 8;

    logic              wr_strobe, rd_phase;
    logic              hit_ctrl, hit_stat, hit_mask, hit_cmd, hit_cstat;
    logic              wr_ctrl, wr_mask, wr_cmd, wr_cstat;
    logic [HSEL_W-1:0] hs_q, hs_eff;
    logic              group_q, group_eff;
    logic [N-1:0]      mask_q;
    logic [N-1:0]      sel;
    logic              hs_absent;
    logic              resume_go;
    logic [N-1:0]      ack;
    logic [7:0]        flags;
    logic              busy;
    logic [2:0]        err;

    assign wr_strobe = psel && penable && pwrite;
    assign rd_phase  = psel && !pwrite;
    assign hit_ctrl  = (paddr == ADDR_W'(OFS_CTRL));
    assign hit_stat  = (paddr == ADDR_W'(OFS_STAT));
    assign hit_mask  = (paddr == ADDR_W'(OFS_MASK));
    assign hit_cmd   = (paddr == ADDR_W'(OFS_CMD));
    assign hit_cstat = (paddr == ADDR_W'(OFS_CMDSTAT));
    assign wr_ctrl   = wr_strobe && hit_ctrl;
    assign wr_mask   = wr_strobe && hit_mask;
    assign wr_cmd    = wr_strobe && hit_cmd;
    assign wr_cstat  = wr_strobe && hit_cstat;

    assign resume_go = wr_ctrl && pwdata[2] && !pwdata[1];

    // A control write acts on the selection it carries.
    assign hs_eff    = wr_ctrl ? pwdata[HS_LSB +: HSEL_W] : hs_q;
    assign group_eff = wr_ctrl ? pwdata[3] : group_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hs_q    <= '0;
            group_q <= 1'b0;
        end else if (wr_ctrl) begin
            hs_q    <= pwdata[HS_LSB +: HSEL_W];
            group_q <= pwdata[3];
        end
    end

    if (N > 1) begin : g_mask
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       mask_q <= '0;
            else if (wr_mask) mask_q <= pwdata[N-1:0];
        end
    end else begin : g_nomask
        assign mask_q = '0;
    end

    dbgrc_select #(.N(N), .HSEL_W(HSEL_W)) u_sel (
        .hs        (hs_eff),
        .group_en  (group_eff),
        .mask      (mask_q),
        .sel       (sel),
        .hs_absent (hs_absent)
    );

    for (genvar i = 0; i < N; i++) begin : g_hart
        dbgrc_hart u_hart (
            .clk        (clk),
            .rst_n      (rst_n),
            .sel        (sel[i]),
            .ctrl_wr    (wr_ctrl),
            .halt_val   (pwdata[1]),
            .resume_go  (resume_go),
            .running    (hart_running[i]),
            .halt_req   (halt_req[i]),
            .resume_req (resume_req[i]),
            .ack        (ack[i])
        );
    end

    dbgrc_status #(.N(N)) u_stat (
        .sel       (sel),
        .hs_absent (hs_absent),
        .group_en  (group_eff),
        .mask      (mask_q),
        .halted    (hart_halted),
        .running   (hart_running),
        .ack       (ack),
        .flags     (flags)
    );

    dbgrc_cmd u_cmd (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmd_wr  (wr_cmd),
        .stat_wr (wr_cstat),
        .wdata   (pwdata),
        .done    (cmd_done),
        .valid   (cmd_valid),
        .busy    (busy),
        .err     (err),
        .f_write (cmd_write),
        .f_xfer  (cmd_xfer),
        .f_size  (cmd_size),
        .f_regno (cmd_regno)
    );

    always_comb begin
        prdata = '0;
        if (rd_phase) begin
            if (hit_ctrl) begin
                prdata[3]                = group_q;
                prdata[HS_LSB +: HSEL_W] = hs_q;
            end else if (hit_stat) begin
                prdata[7:0] = flags;
            end else if (hit_mask) begin
                prdata[N-1:0] = mask_q;
            end else if (hit_cstat) begin
                prdata[0]   = busy;
                prdata[3:1] = err;
            end
        end
    end
endmodule

// File: rtl/dbgrc_checks.sv
module dbgrc_checks #(
    parameter int N = 4
) (
    input logic         clk,
    input logic         rst_n,
    input logic         psel,
    input logic         penable,
    input logic         pwrite,
    input logic [N-1:0] hart_running,
    input logic [N-1:0] halt_req,
    input logic [N-1:0] resume_req,
    input logic         cmd_valid,
    input logic         cmd_xfer,
    input logic [2:0]   cmd_size,
    input logic [15:0]  cmd_regno,
    input logic         cmd_done
);
    // R3: halt lines move only after a write access
    assert_halt_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(psel && penable && pwrite) |=> $stable(halt_req));

    // R4: a pending resume persists until running is seen
    assert_resume_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (resume_req & ~hart_running) != '0 |=>
        (resume_req & $past(resume_req & ~hart_running)) == $past(resume_req & ~hart_running));

    // R8: command fields stay put until done
    assert_cmd_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_done |=> cmd_valid && $stable(cmd_regno) && $stable(cmd_size));

    // R8: done retires the command
    assert_cmd_retire_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_done && !(psel && penable && pwrite) |=> !cmd_valid);

    // R9: non-transfer command hides regno and size
    assert_xfer_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_xfer |-> cmd_regno == 16'd0 && cmd_size == 3'd0);

    // R10: no oversize transfer is ever launched
    assert_size_ok_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_xfer |-> cmd_size <= 3'd2);
endmodule

bind dbg_run_ctrl dbgrc_checks #(.N(N)) u_checks (
    .clk          (clk),
    .rst_n        (rst_n),
    .psel         (psel),
    .penable      (penable),
    .pwrite       (pwrite),
    .hart_running (hart_running),
    .halt_req     (halt_req),
    .resume_req   (resume_req),
    .cmd_valid    (cmd_valid),
    .cmd_xfer     (cmd_xfer),
    .cmd_size     (cmd_size),
    .cmd_regno    (cmd_regno),
    .cmd_done     (cmd_done)
);

// File: tb/dbg_run_ctrl_test.sv
module dbg_run_ctrl_test;
    localparam int N = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [7:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic [N-1:0] hart_halted = '0, hart_running = '1;
    logic [N-1:0] halt_req, resume_req;
    logic        cmd_valid, cmd_write, cmd_xfer, cmd_done = 1'b0;
    logic [2:0]  cmd_size;
    logic [15:0] cmd_regno;

    int checks = 0, errors = 0;

    always #10 clk = ~clk;

    dbg_run_ctrl #(.N(N), .HSEL_W(4), .ADDR_W(8)) uut (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .hart_halted(hart_halted), .hart_running(hart_running),
        .halt_req(halt_req), .resume_req(resume_req),
        .cmd_valid(cmd_valid), .cmd_write(cmd_write), .cmd_xfer(cmd_xfer),
        .cmd_size(cmd_size), .cmd_regno(cmd_regno), .cmd_done(cmd_done));

    // ---------------- reference model ----------------
    int         m_hs;
    bit         m_group;
    bit [N-1:0] m_mask, m_halt, m_res, m_ack;
    bit         m_busy, m_wr, m_xfer;
    bit [2:0]   m_err, m_size;
    bit [15:0]  m_regno;

    function automatic bit [N-1:0] sel_of(int hs, bit g, bit [N-1:0] mk);
        bit [N-1:0] s = '0;
        for (int i = 0; i < N; i++) s[i] = (hs == i) || (g && mk[i]);
        return s;
    endfunction

    function automatic bit [7:0] exp_stat();
        bit [N-1:0] s = sel_of(m_hs, m_group, m_mask);
        bit absent = (m_hs >= N);
        bit ok = (s != 0) && !absent;
        bit [7:0] f = '0;
        f[0] = |(s & hart_halted);
        f[1] = ok && ((s & ~hart_halted) == 0);
        f[2] = |(s & hart_running);
        f[3] = ok && ((s & ~hart_running) == 0);
        f[4] = absent;
        f[5] = absent && !(m_group && (m_mask != 0));
        f[6] = |(s & m_ack);
        f[7] = ok && ((s & ~m_ack) == 0);
        return f;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_hs = 0; m_group = 0; m_mask = '0; m_halt = '0; m_res = '0; m_ack = '0;
            m_busy = 0; m_wr = 0; m_xfer = 0; m_err = 0; m_size = 0; m_regno = 0;
        end else begin
            bit wr;
            bit ctl;
            bit go;
            int nhs;
            bit ng;
            bit [N-1:0] s;
            wr  = psel && penable && pwrite;
            ctl = wr && paddr == 8'h00;
            nhs = ctl ? int'(pwdata[11:8]) : m_hs;
            ng  = ctl ? pwdata[3] : m_group;
            s   = sel_of(nhs, ng, m_mask);
            go  = ctl && pwdata[2] && !pwdata[1];
            for (int i = 0; i < N; i++) begin
                if (ctl && s[i]) m_halt[i] = pwdata[1];
                if (go && s[i]) begin m_res[i] = 1; m_ack[i] = 0; end
                else if (m_res[i] && hart_running[i]) begin m_res[i] = 0; m_ack[i] = 1; end
            end
            m_hs = nhs; m_group = ng;
            if (wr && paddr == 8'h08) m_mask = pwdata[N-1:0];
            if (m_busy) begin
                if (wr && paddr == 8'h0C && m_err == 0) m_err = 1;
                if (cmd_done) m_busy = 0;
            end else if (wr && paddr == 8'h0C && m_err == 0) begin
                if (pwdata[17] && pwdata[22:20] > 2) m_err = 2;
                else begin
                    m_busy = 1; m_xfer = pwdata[17]; m_wr = pwdata[16];
                    m_regno = pwdata[17] ? pwdata[15:0] : 16'd0;
                    m_size  = pwdata[17] ? pwdata[22:20] : 3'd0;
                end
            end
            if (wr && paddr == 8'h10) m_err = m_err & ~pwdata[3:1];
        end
    end

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h at %0t", req, got, exp, $time);
        end
    endtask

    // per-cycle comparison, away from the clock edge
    always @(negedge clk) if (rst_n) begin
        check("R3 halt_req", 32'(halt_req), 32'(m_halt));
        check("R4 resume_req", 32'(resume_req), 32'(m_res));
        check("R8 cmd_valid", 32'(cmd_valid), 32'(m_busy));
        if (m_busy) begin
            check("R9 cmd_regno", 32'(cmd_regno), 32'(m_regno));
            check("R9 cmd_size", 32'(cmd_size), 32'(m_size));
            check("R8 cmd_xfer", 32'(cmd_xfer), 32'(m_xfer));
            check("R8 cmd_write", 32'(cmd_write), 32'(m_wr));
        end
    end

    task automatic apb_write(logic [7:0] a, logic [31:0] d);
        @(negedge clk); psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
        @(negedge clk); penable = 1;
        @(negedge clk); psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic apb_read(logic [7:0] a, output logic [31:0] d);
        @(negedge clk); psel = 1; pwrite = 0; paddr = a; penable = 0;
        @(negedge clk); penable = 1; #2 d = prdata;
        @(negedge clk); psel = 0; penable = 0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(20 * 200000);
        errors++; checks++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] rd;
        idle(3);
        // R12: reset state
        check("R12 halt_req", 32'(halt_req), 0);
        check("R12 resume_req", 32'(resume_req), 0);
        check("R12 cmd_valid", 32'(cmd_valid), 0);
        rst_n = 1;
        idle(2);
        apb_read(8'h00, rd); check("R12 ctrl read", rd, 0);
        apb_read(8'h08, rd); check("R12 mask read", rd, 0);
        apb_read(8'h10, rd); check("R12 cmd status", rd, 0);
        apb_read(8'h04, rd); check("R6 status after reset", rd, 32'(exp_stat()));

        // R3: halt single hart 2
        apb_write(8'h00, 32'h0000_0202);
        check("R3 halt hart2", 32'(halt_req), 32'b0100);
        apb_read(8'h00, rd); check("R2 ctrl readback", rd, 32'h0000_0200);

        // R2: group selection
        apb_write(8'h08, 32'h0000_000A);
        apb_read(8'h08, rd); check("R2 mask readback", rd, 32'hA);
        apb_write(8'h00, 32'h0000_000A);
        check("R2 group halt", 32'(halt_req), 32'b1111);
        apb_write(8'h00, 32'h0000_0100);
        check("R3 only hart1 released", 32'(halt_req), 32'b1101);

        // R6: mixed hart state
        hart_halted = 4'b1101; hart_running = 4'b0010;
        apb_write(8'h00, 32'h0000_0008);
        apb_read(8'h04, rd); check("R6 group status", rd, 32'(exp_stat()));
        check("R6 any halted, not all", rd[1:0], 2'b01);

        // R4: halt and resume together start nothing
        apb_write(8'h00, 32'h0000_0006);
        check("R4 no resume on both bits", 32'(resume_req), 0);

        // R4/R5: resume hart 0 with running held low
        apb_write(8'h00, 32'h0000_0004);
        check("R4 resume raised", 32'(resume_req), 32'b0001);
        check("R3 hart0 halt dropped", 32'(halt_req[0]), 0);
        idle(3);
        check("R4 resume held", 32'(resume_req), 32'b0001);
        apb_read(8'h04, rd); check("R5 ack clear while waiting", rd[6], 0);
        hart_running[0] = 1'b1; hart_halted[0] = 1'b0;
        idle(2);
        check("R4 resume dropped", 32'(resume_req), 0);
        apb_read(8'h04, rd); check("R5 ack set", rd[7:6], 2'b11);

        // R7: nonexistent hart index
        apb_write(8'h00, 32'h0000_0902);
        check("R7 no request to absent hart", 32'(halt_req), 32'(m_halt));
        apb_read(8'h04, rd); check("R7 absent alone", rd[5:4], 2'b11);
        check("R6 all flags clear", {rd[7], rd[3], rd[1]}, 0);
        apb_write(8'h08, 32'h0000_0001);
        apb_write(8'h00, 32'h0000_0908);
        apb_read(8'h04, rd); check("R7 absent with group", rd[5:4], 2'b01);
        check("R6 status group+absent", rd, 32'(exp_stat()));

        // R1: misaligned accesses do nothing
        apb_write(8'h01, 32'h0000_000A);
        apb_read(8'h00, rd); check("R1 misaligned write ignored", rd, 32'h0000_0908);
        apb_read(8'h05, rd); check("R1 misaligned read zero", rd, 0);

        // R8/R11: command launch and busy rejection
        apb_write(8'h0C, 32'h0023_1001);
        check("R8 launched", 32'(cmd_valid), 1);
        check("R8 regno", 32'(cmd_regno), 32'h1001);
        apb_write(8'h0C, 32'h0002_0005);
        check("R11 in-flight regno kept", 32'(cmd_regno), 32'h1001);
        apb_read(8'h10, rd); check("R11 busy error", rd, 32'h3);
        @(negedge clk); cmd_done = 1; @(negedge clk); cmd_done = 0;
        check("R8 retired", 32'(cmd_valid), 0);
        apb_write(8'h0C, 32'h0002_0007);
        check("R11 ignored while error", 32'(cmd_valid), 0);
        apb_write(8'h10, 32'h0000_000E);
        apb_read(8'h10, rd); check("R11 error cleared", rd, 0);

        // R9: transfer clear hides regno/size
        apb_write(8'h0C, 32'h0070_0055);
        check("R9 launch without transfer", 32'(cmd_valid), 1);
        check("R9 regno zeroed", 32'(cmd_regno), 0);
        check("R9 size zeroed", 32'(cmd_size), 0);
        @(negedge clk); cmd_done = 1; @(negedge clk); cmd_done = 0;

        // R10: oversize transfer rejected
        apb_write(8'h0C, 32'h0032_0010);
        check("R10 not launched", 32'(cmd_valid), 0);
        apb_read(8'h10, rd); check("R10 notsup error", rd, 32'h4);

        idle(4);
        finish_run();
    end
endmodule